// File: doc/BRIEF.md
# Pulse Descriptor Word Generator

This block stands in for a radar receiver when a signal processor has to be exercised without one. A free-running time-of-arrival counter runs on every clock. When a pulse-event tick is accepted, the current count is captured together with the programmed pulse width, amplitude, carrier frequency and repetition interval. The five values form one 128-bit descriptor.

The descriptor leaves the block as four 32-bit beats on consecutive clocks. Each beat carries a 2-bit word address and a one-cycle strobe. A sequencer with five named states controls the transfer: `ST_IDLE` waits for an event, and `ST_BEAT0` to `ST_BEAT3` each drive one beat. The transitions are as follows. `ST_IDLE` goes to `ST_BEAT0` on an accepted tick, and otherwise stays in `ST_IDLE`. `ST_BEAT0` goes to `ST_BEAT1`, `ST_BEAT1` to `ST_BEAT2`, `ST_BEAT2` to `ST_BEAT3`, and `ST_BEAT3` back to `ST_IDLE`, each unconditionally. A tick that arrives while the sequencer is in any beat state is discarded, and a sticky overflow flag records the loss.

The event ticks usually come from a periodic rate generator elsewhere on the chip. The enable input lets the consumer hold off new descriptors without disturbing the timestamp counter.

Top module: `pdw_gen`

## Requirements
- R1: After reset, the strobe and the overflow flag are low, the word address and the data bus are zero, and the time-of-arrival counter is zero. A tick sampled on the first clock edge after reset is released therefore captures time of arrival 0.
- R2: The time-of-arrival counter (TOA_W bits, default 36) advances by one on every clock edge and wraps from its all-ones value to zero. A descriptor's time of arrival is the counter value present at the clock edge that accepts the tick.
- R3: A tick sampled high while the sequencer is idle and the enable is high is accepted. On the four following cycles the strobe is high with word addresses 0, 1, 2 and 3 in that order, one cycle each. The strobe is low in the cycle after address 3.
- R4: The beat at address 0 carries time-of-arrival bits [31:0]. When TOA_W is 32 or less, it carries the whole count zero-extended.
- R5: The beat at address 1 carries time-of-arrival bits [35:32] in bits [3:0], with zeros there when TOA_W is 32 or less. It carries the 8-bit amplitude in bits [11:4] and the 20-bit pulse width in bits [31:12].
- R6: The beat at address 2 carries the 32-bit frequency value and the beat at address 3 carries the 32-bit repetition-interval value.
- R7: The parameter inputs and the time of arrival are sampled at the accepting edge. Changing the parameter inputs while the beats are being sent does not alter any beat of that descriptor.
- R8: A tick sampled while any beat is being sent, including the beat at address 3, produces no descriptor. It sets the overflow flag, which then stays high until reset.
- R9: A tick sampled while the sequencer is idle and the enable is low produces no beats and leaves the overflow flag low.
- R10: The data bus is zero in every cycle in which the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tick | input | 1 | Pulse-event tick, one cycle per event |
| tx_enable | input | 1 | Permits acceptance of new events when high |
| cfg_width | input | 20 | Pulse width value |
| cfg_amp | input | 8 | Amplitude value |
| cfg_freq | input | 32 | Frequency value |
| cfg_pri | input | 32 | Repetition-interval value |
| out_data | output | 32 | Descriptor beat data |
| out_addr | output | 2 | Word address of the current beat |
| out_strobe | output | 1 | High for one cycle per valid beat |
| overflow_flag | output | 1 | Sticky flag: an event was dropped |

## Verification
The hardest condition to reach from the ports is the timestamp wrap, because a 36-bit counter needs about 6.9e10 clocks to roll over. The bench therefore runs a second instance with a 12-bit counter beside the default one. Both instances receive the same long sweep of descriptors with varying spacing and parameter patterns. The sweep crosses the wrap, and two targeted events land on the all-ones count and on the zero count right after it. The bench also places a tick exactly on the last beat to cover the drop boundary. It places another tick on the first idle cycle after a descriptor, which must be accepted.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int ADDR_W    = $clog2(NUM_WORDS);
    localparam int HI_W      = 4;
    localparam int AMP_W     = 8;
    localparam int PW_W      = 20;
    localparam int DESC_W    = WORD_W * NUM_WORDS;
    localparam int TOA_MAX_W = WORD_W + HI_W;

    // Packed from most significant: word 3, word 2, word 1, word 0
    typedef struct packed {
        logic [WORD_W-1:0] pri;
        logic [WORD_W-1:0] freq;
        logic [PW_W-1:0]   width;
        logic [AMP_W-1:0]  amp;
        logic [HI_W-1:0]   toa_hi;
        logic [WORD_W-1:0] toa_lo;
    } pdw_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BEAT0,
        ST_BEAT1,
        ST_BEAT2,
        ST_BEAT3
    } state_t;

endpackage

// File: rtl/pdw_toa_counter.sv
module pdw_toa_counter #(
    parameter int CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pdw_capture.sv
module pdw_capture
    import pdw_pkg::*;
#(
    parameter int TOA_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TOA_W-1:0] toa,
    input  logic [PW_W-1:0]  width,
    input  logic [AMP_W-1:0] amp,
    input  logic [WORD_W-1:0] freq,
    input  logic [WORD_W-1:0] pri,
    output pdw_t             desc_q
);

    logic [WORD_W-1:0] toa_lo;
    logic [HI_W-1:0]   toa_hi;
    pdw_t              desc_d;

    generate
        if (TOA_W > WORD_W) begin : g_wide_toa
            assign toa_lo = toa[WORD_W-1:0];
            assign toa_hi = HI_W'(toa[TOA_W-1:WORD_W]);
        end else begin : g_narrow_toa
            assign toa_lo = WORD_W'(toa);
            assign toa_hi = '0;
        end
    endgenerate

    always_comb begin
        desc_d.pri    = pri;
        desc_d.freq   = freq;
        desc_d.width  = width;
        desc_d.amp    = amp;
        desc_d.toa_hi = toa_hi;
        desc_d.toa_lo = toa_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if (load) begin
            desc_q <= desc_d;
        end
    end

endmodule

// File: rtl/pdw_beat_mux.sv
module pdw_beat_mux
    import pdw_pkg::*;
(
    input  pdw_t              desc,
    input  logic [ADDR_W-1:0] sel,
    output logic [WORD_W-1:0] word
);

    logic [DESC_W-1:0] flat;
    logic [WORD_W-1:0] words [NUM_WORDS];

    assign flat = desc;

    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slice
            assign words[g] = flat[g*WORD_W +: WORD_W];
        end
    endgenerate

    assign word = words[sel];

endmodule

// File: rtl/pdw_gen.sv
module pdw_gen
    import pdw_pkg::*;
#(
    parameter int TOA_W = 36
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_tick,
    input  logic        tx_enable,
    input  logic [19:0] cfg_width,
    input  logic [7:0]  cfg_amp,
    input  logic [31:0] cfg_freq,
    input  logic [31:0] cfg_pri,
    output logic [31:0] out_data,
    output logic [1:0]  out_addr,
    output logic        out_strobe,
    output logic        overflow_flag
);

    state_t            state;
    state_t            state_nxt;
    logic              accept;
    logic              busy;
    logic [TOA_W-1:0]  toa_cnt;
    pdw_t              desc_q;
    logic [ADDR_W-1:0] beat_idx;
    logic [WORD_W-1:0] beat_word;

    pdw_toa_counter #(
        .CNT_W (TOA_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .count (toa_cnt)
    );

    pdw_capture #(
        .TOA_W (TOA_W)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .toa    (toa_cnt),
        .width  (cfg_width),
        .amp    (cfg_amp),
        .freq   (cfg_freq),
        .pri    (cfg_pri),
        .desc_q (desc_q)
    );

    pdw_beat_mux u_mux (
        .desc (desc_q),
        .sel  (beat_idx),
        .word (beat_word)
    );

    assign busy   = (state != ST_IDLE);
    assign accept = !busy && ev_tick && tx_enable;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = accept ? ST_BEAT0 : ST_IDLE;
            ST_BEAT0: state_nxt = ST_BEAT1;
            ST_BEAT1: state_nxt = ST_BEAT2;
            ST_BEAT2: state_nxt = ST_BEAT3;
            ST_BEAT3: state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Dropped-event flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow_flag <= 1'b0;
        end else if (ev_tick && busy) begin
            overflow_flag <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        out_strobe = 1'b0;
        beat_idx   = '0;
        unique case (state)
            ST_IDLE:  begin out_strobe = 1'b0; beat_idx = 2'd0; end
            ST_BEAT0: begin out_strobe = 1'b1; beat_idx = 2'd0; end
            ST_BEAT1: begin out_strobe = 1'b1; beat_idx = 2'd1; end
            ST_BEAT2: begin out_strobe = 1'b1; beat_idx = 2'd2; end
            ST_BEAT3: begin out_strobe = 1'b1; beat_idx = 2'd3; end
            default:  begin out_strobe = 1'b0; beat_idx = 2'd0; end
        endcase
        out_addr = beat_idx;
        out_data = out_strobe ? beat_word : '0;
    end

endmodule

// File: rtl/pdw_gen_chk.sv
module pdw_gen_chk
    import pdw_pkg::*;
#(
    parameter int TOA_W = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_tick,
    input logic             out_strobe,
    input logic [1:0]       out_addr,
    input logic [31:0]      out_data,
    input logic             overflow_flag,
    input logic [TOA_W-1:0] toa_cnt,
    input pdw_t             desc_q
);

    // R2
    toa_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toa_cnt == {TOA_W{1'b1}}) |=> (toa_cnt == '0));

    // R3
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_strobe) |-> (out_addr == 2'd0));

    // R3
    beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && out_addr != 2'd3) |=>
            (out_strobe && out_addr == $past(out_addr) + 2'd1));

    // R3
    last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && out_addr == 2'd3) |=> !out_strobe);

    // R7
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && out_addr != 2'd0) |-> $stable(desc_q));

    // R8
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tick && out_strobe) |=> overflow_flag);

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> overflow_flag);

    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_strobe |-> (out_data == '0));

endmodule

bind pdw_gen pdw_gen_chk #(.TOA_W(TOA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_tick       (ev_tick),
    .out_strobe    (out_strobe),
    .out_addr      (out_addr),
    .out_data      (out_data),
    .overflow_flag (overflow_flag),
    .toa_cnt       (toa_cnt),
    .desc_q        (desc_q)
);

// File: tb/tb_pdw_gen.sv
`timescale 1ns/1ps
module tb_pdw_gen;

    localparam int SMALL_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_tick = 1'b0;
    logic        tx_enable = 1'b0;
    logic [19:0] cfg_width = '0;
    logic [7:0]  cfg_amp = '0;
    logic [31:0] cfg_freq = '0;
    logic [31:0] cfg_pri = '0;

    logic [31:0] d_data, s_data;
    logic [1:0]  d_addr, s_addr;
    logic        d_strobe, s_strobe;
    logic        d_ovf, s_ovf;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    longint unsigned n;

    always #4 clk = ~clk;

    pdw_gen dut (
        .clk (clk), .rst_n (rst_n), .ev_tick (ev_tick), .tx_enable (tx_enable),
        .cfg_width (cfg_width), .cfg_amp (cfg_amp), .cfg_freq (cfg_freq), .cfg_pri (cfg_pri),
        .out_data (d_data), .out_addr (d_addr), .out_strobe (d_strobe), .overflow_flag (d_ovf)
    );

    pdw_gen #(.TOA_W(SMALL_W)) dut_small (
        .clk (clk), .rst_n (rst_n), .ev_tick (ev_tick), .tx_enable (tx_enable),
        .cfg_width (cfg_width), .cfg_amp (cfg_amp), .cfg_freq (cfg_freq), .cfg_pri (cfg_pri),
        .out_data (s_data), .out_addr (s_addr), .out_strobe (s_strobe), .overflow_flag (s_ovf)
    );

    // Elapsed clock edges since reset release: the expected timestamp
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(req, "strobe low (default)", 64'(d_strobe), 64'd0);
        chk(req, "strobe low (small)",   64'(s_strobe), 64'd0);
        chk("R10", "idle bus zero (default)", 64'(d_data), 64'd0);
        chk("R10", "idle bus zero (small)",   64'(s_data), 64'd0);
    endtask

    // Called just after a falling edge; returns just after a falling edge in idle.
    task automatic send_one(input string toa_req, input logic [19:0] w, input logic [7:0] a,
                            input logic [31:0] f, input logic [31:0] p, input bit late_tick);
        logic [35:0]      t;
        logic [SMALL_W-1:0] ts;
        logic [31:0]      ed [4];
        logic [31:0]      es [4];
        t  = n[35:0];
        ts = n[SMALL_W-1:0];
        ed[0] = t[31:0];
        ed[1] = {w, a, t[35:32]};
        ed[2] = f;
        ed[3] = p;
        es[0] = 32'(ts);
        es[1] = {w, a, 4'h0};
        es[2] = f;
        es[3] = p;
        ev_tick = 1'b1;
        tx_enable = 1'b1;
        cfg_width = w; cfg_amp = a; cfg_freq = f; cfg_pri = p;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            ev_tick = late_tick && (b == 3);
            if (b == 0) begin
                // R7: disturb parameters after the accepting edge
                cfg_width = ~w; cfg_amp = ~a; cfg_freq = ~f; cfg_pri = ~p;
            end
            chk("R3", "strobe (default)", 64'(d_strobe), 64'd1);
            chk("R3", "strobe (small)",   64'(s_strobe), 64'd1);
            chk("R3", "addr (default)",   64'(d_addr), 64'(b));
            chk("R3", "addr (small)",     64'(s_addr), 64'(b));
            case (b)
                0: begin
                    chk({toa_req, " R4"}, "word0 (default)", 64'(d_data), 64'(ed[0]));
                    chk({toa_req, " R4"}, "word0 (small)",   64'(s_data), 64'(es[0]));
                end
                1: begin
                    chk("R5 R7", "word1 (default)", 64'(d_data), 64'(ed[1]));
                    chk("R5 R7", "word1 (small)",   64'(s_data), 64'(es[1]));
                end
                default: begin
                    chk("R6 R7", "word2/3 (default)", 64'(d_data), 64'(ed[b]));
                    chk("R6 R7", "word2/3 (small)",   64'(s_data), 64'(es[b]));
                end
            endcase
        end
        @(negedge clk);
        ev_tick = 1'b0;
        check_idle("R3");
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "strobe", 64'(d_strobe), 64'd0);
        chk("R1", "addr",   64'(d_addr), 64'd0);
        chk("R1", "data",   64'(d_data), 64'd0);
        chk("R1", "overflow", 64'(d_ovf), 64'd0);
        chk("R1", "small strobe", 64'(s_strobe), 64'd0);
        chk("R1", "small overflow", 64'(s_ovf), 64'd0);

        rst_n = 1'b1;
        // R1: first edge after release captures TOA 0
        chk("R1", "bench count at release", n, 64'd0);
        send_one("R1", 20'h12345, 8'hA5, 32'hDEADBEEF, 32'h00C0FFEE, 1'b0);

        // Sweep: varied parameters and spacing (gap 0 is the first idle cycle)
        for (int i = 0; i < 1200; i++) begin
            send_one("R2", 20'(i * 7919 + 3), 8'(i * 37), 32'(i * 32'd2654435761),
                     32'(i * 40503 + 1000), 1'b0);
            repeat (i % 3) @(negedge clk);
        end

        // R2: targeted wrap boundary of the narrow counter
        while (n[SMALL_W-1:0] != {SMALL_W{1'b1}}) @(negedge clk);
        send_one("R2", 20'hFFFFF, 8'hFF, 32'hFFFFFFFF, 32'h80000001, 1'b0);
        while (n[SMALL_W-1:0] != '0) @(negedge clk);
        send_one("R2", 20'h00001, 8'h01, 32'h00000002, 32'h00000003, 1'b0);

        // R9: enable low ignores the tick
        tx_enable = 1'b0;
        ev_tick = 1'b1;
        @(negedge clk);
        ev_tick = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check_idle("R9");
            @(negedge clk);
        end
        chk("R9", "overflow after gated tick", 64'(d_ovf), 64'd0);
        chk("R8", "no overflow before drop (small)", 64'(s_ovf), 64'd0);

        // R8: tick on the last beat is dropped
        send_one("R2", 20'h0BEEF, 8'h3C, 32'h11111111, 32'h22222222, 1'b1);
        chk("R8", "overflow set (default)", 64'(d_ovf), 64'd1);
        chk("R8", "overflow set (small)",   64'(s_ovf), 64'd1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check_idle("R8");
        end

        // R8: flag stays set across a later clean descriptor
        send_one("R2", 20'h00777, 8'h77, 32'h77777777, 32'h07070707, 1'b0);
        chk("R8", "overflow sticky", 64'(d_ovf), 64'd1);

        done = 1'b1;
        report();
    end

endmodule